// File: doc/BRIEF.md
# Predicated Halfword Gather Sequencer

This block carries out one gather-load operation over a vector register image. It takes a scalar base address, one index per element and one predicate bit per element. For each element whose predicate bit is set, it computes the address as the base plus twice the index. It then issues a single halfword read on a simple request/response memory port and sign-extends the returned 16 bits into that element's 64-bit lane. Elements whose predicate bit is clear are never requested and end as zero.

A pulse on the start input is accepted only while the block is idle. The block then walks the active elements in ascending order and keeps at most one read in flight. It finishes with a one-cycle done pulse. If the port reports an error for an active element, the walk stops at that element. The block then raises the fault flag with the element's number and leaves the published result vector as it was.

Top module: `gather_seq`

## Requirements
- R1: The 16-bit value returned for an active element appears in that element's 64-bit lane of `result_o`, sign-extended: bits 63..16 all equal bit 15 of the returned value. Lane i occupies bits 64*i+63 down to 64*i.
- R2: The address requested for element i equals `base_i` plus the element's index shifted left by one, taken modulo 2^64 with no overflow indication.
- R3: Every element whose bit in `pred_i` is 0 ends as an all-zero lane in `result_o` after a completion without fault.
- R4: No memory request is issued for an element whose predicate bit is 0.
- R5: An element whose predicate bit is 0 never causes a fault, even when its computed address would draw an error from memory.
- R6: Active elements are requested in ascending element order. `req_valid_o` stays high with a stable `req_addr_o` until `rsp_valid_i` arrives, and the next request comes only after that response.
- R7: When `rsp_err_i` accompanies a response, the operation ends with `done_o` and `fault_o` both high and `fault_elem_o` set to that element's number. No later element is requested, and `result_o` keeps the value of the last completion without fault.
- R8: With all predicate bits 0, `done_o` is high in the second cycle after the start is accepted, no request is made and the result is all zero.
- R9: `busy_o` is high from the cycle after an accepted start until `done_o` rises, and `done_o` lasts exactly one cycle. A `start_i` seen while busy is ignored and leaves the running operation unchanged.
- R10: Indices are widened to the address width by sign extension when `idx_signed_i` is 1 and by zero extension when it is 0. At the default 64-bit index width, both settings give identical addresses and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| idx_signed_i | input | 1 | 1: indices are signed, 0: unsigned |
| base_i | input | ADDR_W | Scalar base address |
| idx_vec_i | input | NUM_EL*IDX_W | Per-element indices, element 0 in the low bits |
| pred_i | input | NUM_EL | Per-element predicate, bit i governs element i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Completion ended by a memory error |
| fault_elem_o | output | EL_W | Number of the element that faulted |
| result_o | output | VLEN_BITS | Assembled destination vector |
| req_valid_o | output | 1 | Halfword read request pending |
| req_addr_o | output | ADDR_W | Byte address of the read |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_data_i | input | 16 | Returned halfword |
| rsp_err_i | input | 1 | Response carries an access error |

## Verification
On every cycle, the assertions check several properties. A request only targets an element whose predicate bit is set, and a pending request holds its address until answered. A reported fault names an active element. Completions without fault carry zero in the lanes of inactive elements, and done is a one-cycle pulse that never coincides with busy. The bench's scenarios are the only evidence for the rest: the sign-extended values, the wrapped addresses, the ascending request order, the early stop with the result left unchanged, the fixed latency of an empty predicate, and the start ignored while busy. The bench sweeps every predicate mask under both index modes and three response latencies.

// File: rtl/gather_pkg.sv
package gather_pkg;
   localparam int GS_ELEM_W = 64;
   localparam int GS_HALF_W = 16;

   typedef enum logic [1:0] {
      GS_IDLE = 2'd0,
      GS_SEEK = 2'd1,
      GS_WAIT = 2'd2
   } gs_state_e;

   function automatic logic [GS_ELEM_W-1:0] gs_sext(input logic [GS_HALF_W-1:0] h);
      return {{(GS_ELEM_W-GS_HALF_W){h[GS_HALF_W-1]}}, h};
   endfunction
endpackage

// File: rtl/gather_pick.sv
module gather_pick #(
   parameter int NUM_EL = 4,
   parameter int EL_W   = 2
) (
   input  logic [NUM_EL-1:0] mask_i,
   output logic              any_o,
   output logic [EL_W-1:0]   idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NUM_EL - 1; i >= 0; i--) begin
         if (mask_i[i]) idx_o = EL_W'(i);
      end
   end
   assign any_o = |mask_i;
endmodule

// File: rtl/gather_agen.sv
module gather_agen #(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 64
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              signed_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] ext;

   generate
      if (IDX_W == ADDR_W) begin : g_same
         assign ext = idx_i;
      end else begin : g_widen
         localparam int PAD = ADDR_W - IDX_W;
         assign ext = signed_i ? {{PAD{idx_i[IDX_W-1]}}, idx_i} : {{PAD{1'b0}}, idx_i};
      end
   endgenerate

   assign addr_o = base_i + {ext[ADDR_W-2:0], 1'b0};
endmodule

// File: rtl/gather_seq.sv
module gather_seq
   import gather_pkg::*;
#(
   parameter int VLEN_BITS = 256,
   parameter int ADDR_W    = 64,
   parameter int IDX_W     = 64,
   localparam int NUM_EL   = VLEN_BITS / GS_ELEM_W,
   localparam int EL_W     = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    idx_signed_i,
   input  logic [ADDR_W-1:0]       base_i,
   input  logic [NUM_EL*IDX_W-1:0] idx_vec_i,
   input  logic [NUM_EL-1:0]       pred_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    fault_o,
   output logic [EL_W-1:0]         fault_elem_o,
   output logic [VLEN_BITS-1:0]    result_o,
   output logic                    req_valid_o,
   output logic [ADDR_W-1:0]       req_addr_o,
   input  logic                    rsp_valid_i,
   input  logic [GS_HALF_W-1:0]    rsp_data_i,
   input  logic                    rsp_err_i
);
   generate
      if (VLEN_BITS % 128 != 0 || VLEN_BITS < 128 || VLEN_BITS > 2048) begin : g_bad_vlen
         $error("VLEN_BITS must be a multiple of 128 in 128..2048");
      end
      if (IDX_W > ADDR_W || IDX_W < 2) begin : g_bad_idx
         $error("IDX_W must lie in 2..ADDR_W");
      end
   endgenerate

   gs_state_e                 state_q;
   logic [ADDR_W-1:0]         base_q;
   logic [NUM_EL*IDX_W-1:0]   idx_q;
   logic [NUM_EL-1:0]         pred_q;
   logic [NUM_EL-1:0]         pend_q;
   logic                      mode_q;
   logic [VLEN_BITS-1:0]      work_q;
   logic [VLEN_BITS-1:0]      result_q;
   logic [EL_W-1:0]           cur_q;
   logic [ADDR_W-1:0]         addr_q;
   logic                      done_q;
   logic                      fault_q;
   logic [EL_W-1:0]           fel_q;

   logic                      pick_any;
   logic [EL_W-1:0]           pick_idx;
   logic [ADDR_W-1:0]         next_addr;

   gather_pick #(.NUM_EL(NUM_EL), .EL_W(EL_W)) u_pick (
      .mask_i (pend_q),
      .any_o  (pick_any),
      .idx_o  (pick_idx)
   );

   gather_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
      .base_i   (base_q),
      .idx_i    (idx_q[pick_idx*IDX_W +: IDX_W]),
      .signed_i (mode_q),
      .addr_o   (next_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= GS_IDLE;
         base_q   <= '0;
         idx_q    <= '0;
         pred_q   <= '0;
         pend_q   <= '0;
         mode_q   <= 1'b0;
         work_q   <= '0;
         result_q <= '0;
         cur_q    <= '0;
         addr_q   <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
         fel_q    <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            GS_IDLE: begin
               if (start_i) begin
                  base_q  <= base_i;
                  idx_q   <= idx_vec_i;
                  pred_q  <= pred_i;
                  pend_q  <= pred_i;
                  mode_q  <= idx_signed_i;
                  work_q  <= '0;
                  fault_q <= 1'b0;
                  state_q <= GS_SEEK;
               end
            end
            GS_SEEK: begin
               if (!pick_any) begin
                  done_q   <= 1'b1;
                  result_q <= work_q;
                  state_q  <= GS_IDLE;
               end else begin
                  cur_q   <= pick_idx;
                  addr_q  <= next_addr;
                  state_q <= GS_WAIT;
               end
            end
            GS_WAIT: begin
               if (rsp_valid_i) begin
                  if (rsp_err_i) begin
                     fault_q <= 1'b1;
                     fel_q   <= cur_q;
                     done_q  <= 1'b1;
                     state_q <= GS_IDLE;
                  end else begin
                     work_q[cur_q*GS_ELEM_W +: GS_ELEM_W] <= gs_sext(rsp_data_i);
                     pend_q[cur_q] <= 1'b0;
                     state_q       <= GS_SEEK;
                  end
               end
            end
            default: state_q <= GS_IDLE;
         endcase
      end
   end

   assign busy_o       = (state_q != GS_IDLE);
   assign done_o       = done_q;
   assign fault_o      = fault_q;
   assign fault_elem_o = fel_q;
   assign result_o     = result_q;
   assign req_valid_o  = (state_q == GS_WAIT);
   assign req_addr_o   = addr_q;

   // R4: a request only ever targets an active element
   a_r4_req_active: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> pred_q[cur_q]);

   // R6: an unanswered request stays up with the same address
   a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !rsp_valid_i) |=> (req_valid_o && $stable(req_addr_o)));

   // R5: a reported fault always names an active element
   a_r5_fault_active: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && fault_o) |-> pred_q[fault_elem_o]);

   // R9: done is a single-cycle pulse and the block is idle with it
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   generate
      for (genvar g = 0; g < NUM_EL; g++) begin : g_lane_chk
         // R3: inactive lanes are zero after a completion without fault
         a_r3_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && !fault_o && !pred_q[g]) |-> (result_o[g*GS_ELEM_W +: GS_ELEM_W] == '0));
      end
   endgenerate
endmodule

// File: tb/gather_seq_tb.sv
module gather_seq_tb;
   localparam int VL = 256;
   localparam int NE = VL / 64;
   localparam int EW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic           idx_signed_i = 1'b0;
   logic [63:0]    base_i = '0;
   logic [NE*64-1:0] idx_vec_i = '0;
   logic [NE-1:0]  pred_i = '0;
   logic           busy_o, done_o, fault_o;
   logic [EW-1:0]  fault_elem_o;
   logic [VL-1:0]  result_o;
   logic           req_valid_o;
   logic [63:0]    req_addr_o;
   logic           rsp_valid_i = 1'b0;
   logic [15:0]    rsp_data_i = '0;
   logic           rsp_err_i = 1'b0;

   gather_seq #(.VLEN_BITS(VL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_signed_i(idx_signed_i),
      .base_i(base_i), .idx_vec_i(idx_vec_i), .pred_i(pred_i),
      .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_elem_o(fault_elem_o),
      .result_o(result_o), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
      .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_err_i(rsp_err_i)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int lat = 0;
   int wcnt = 0;
   logic [63:0] log_a [0:NE-1];
   int log_n = 0;
   logic [VL-1:0] prev_res = '0;

   function automatic logic mem_err(input logic [63:0] a);
      return a[63:56] == 8'hEE;
   endfunction
   function automatic logic [15:0] mem_data(input logic [63:0] a);
      return a[16:1] ^ a[32:17] ^ 16'h8421;
   endfunction

   // memory model, driven at the falling edge
   always @(negedge clk) begin
      if (req_valid_o) begin
         if (wcnt >= lat) begin
            rsp_valid_i <= 1'b1;
            rsp_data_i  <= mem_data(req_addr_o);
            rsp_err_i   <= mem_err(req_addr_o);
            if (log_n < NE) log_a[log_n] = req_addr_o;
            log_n = log_n + 1;
            wcnt = 0;
         end else begin
            rsp_valid_i <= 1'b0;
            wcnt = wcnt + 1;
         end
      end else begin
         rsp_valid_i <= 1'b0;
         rsp_err_i   <= 1'b0;
         wcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", rq, act, exp);
      end
   endtask

   task automatic run_op(input logic [63:0] base, input logic [NE*64-1:0] idxv,
                         input logic [NE-1:0] pred, input logic mode, input int l,
                         input bit poke_start);
      logic [VL-1:0] exp_res;
      logic [63:0]   exp_a [0:NE-1];
      int            exp_n;
      bit            exp_f;
      int            exp_fe;
      int            cyc;
      exp_res = '0; exp_n = 0; exp_f = 0; exp_fe = 0;
      for (int e = 0; e < NE; e++) begin
         logic [63:0] a;
         a = base + {idxv[e*64 +: 63], 1'b0};
         if (pred[e] && !exp_f) begin
            exp_a[exp_n] = a;
            exp_n++;
            if (mem_err(a)) begin
               exp_f = 1; exp_fe = e;
            end else begin
               exp_res[e*64 +: 64] = {{48{mem_data(a)[15]}}, mem_data(a)};
            end
         end
      end
      if (exp_f) exp_res = prev_res;
      lat = l; log_n = 0;
      @(negedge clk);
      base_i = base; idx_vec_i = idxv; pred_i = pred; idx_signed_i = mode; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      if (poke_start) begin
         chk(busy_o == 1'b1, "R9 busy after start", VL'(busy_o), VL'(1));
         base_i = 64'hEE00_0000_0000_0000; pred_i = '1; start_i = 1'b1;
      end
      cyc = 0;
      while (!done_o && cyc < 200) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         start_i = 1'b0;
      end
      if (pred == '0)
         chk(cyc == 1, "R8 empty predicate latency", VL'(cyc), VL'(1));
      chk(done_o == 1'b1, "R9 done reached", VL'(done_o), VL'(1));
      chk(fault_o == exp_f, "R7 fault flag", VL'(fault_o), VL'(exp_f));
      if (exp_f) chk(fault_elem_o == EW'(exp_fe), "R7 fault element", VL'(fault_elem_o), VL'(exp_fe));
      chk(result_o == exp_res, "R1 R3 result vector", result_o, exp_res);
      chk(log_n == exp_n, "R4 request count", VL'(log_n), VL'(exp_n));
      for (int k = 0; k < exp_n && k < log_n; k++)
         chk(log_a[k] == exp_a[k], "R2 R6 request address/order", VL'(log_a[k]), VL'(exp_a[k]));
      @(posedge clk);
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done single cycle", VL'({done_o, busy_o}), VL'(0));
      if (!exp_f) prev_res = exp_res;
   endtask

   initial begin
      logic [NE*64-1:0] iv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && req_valid_o == 0, "reset outputs",
          VL'({busy_o, done_o, req_valid_o}), VL'(0));
      chk(result_o == '0, "reset result", result_o, '0);
      rst_n = 1'b1;
      // sweep all masks, both index modes (R10), three latencies
      for (int m = 0; m < (1 << NE); m++) begin
         for (int md = 0; md < 2; md++) begin
            for (int l = 0; l < 3; l++) begin
               for (int e = 0; e < NE; e++) begin
                  logic [63:0] v;
                  v = 64'(e + 1) * 64'h0000_0001_0000_0133 + 64'(m * 7 + l);
                  iv[e*64 +: 64] = (e % 2 == 1) ? -v : v;
               end
               run_op(64'h1000_0000_0000_0F00 + 64'(m) * 64'h40, iv, NE'(m), md[0], l, (m == 5 && l == 1));
            end
         end
      end
      // R2: address wraps modulo 2^64
      iv = '0;
      iv[0 +: 64] = 64'd16;
      iv[64 +: 64] = 64'h8000_0000_0000_0004;
      run_op(64'hFFFF_FFFF_FFFF_FFF0, iv, 4'b0011, 1'b1, 0, 0);
      // R7: fault on element 1 stops the walk, result kept
      iv[0 +: 64] = 64'd3;
      iv[64 +: 64] = 64'h7700_0000_0000_0000;
      iv[128 +: 64] = 64'd9;
      iv[192 +: 64] = 64'd11;
      run_op(64'h1000, iv, 4'b1011, 1'b0, 1, 0);
      // R5: the same bad address on an inactive element raises no fault
      run_op(64'h1000, iv, 4'b1101, 1'b1, 2, 0);
      // R7: fault on the last element
      iv[192 +: 64] = 64'h7700_0000_0000_0010;
      run_op(64'h2000, iv, 4'b1001, 1'b0, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule